// File: doc/BRIEF.md
# Sixteen-bit ALU with flag word

This block performs one arithmetic or logic operation per update strobe on two sixteen-bit operands and keeps a sixteen-bit flag word with a fixed bit layout. The operation set is add, add with carry, subtract, subtract with borrow, AND, OR, XOR and pass-through. Each operation can act on the full word or on the low byte only. The result and the flag word are both registered. They change only on a clock edge where the strobe is high.

Six condition flags follow each arithmetic operation. Logic operations refresh three of them and clear the other three. Three control flags are held in the same word. Only dedicated set and clear commands change them. A datapath block uses the result port and the flag word together. Later add-with-carry and subtract-with-borrow commands chain through the stored carry.

Top module: `alu16_flags`

## Requirements
- R1: The flag word places carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. Bits 1, 3, 5 and 12 to 15 always read zero.
- R2: While reset is low, and after it, the result and the flag word are zero.
- R3: Opcode 0 adds and opcode 1 adds plus the stored carry. Carry is set on a carry out of the top bit of the selected width.
- R4: Opcode 2 subtracts B from A and opcode 3 also subtracts the stored carry. Carry is set when a borrow occurs in the selected width.
- R5: After an add or subtract opcode, auxiliary carry is set on a carry out of bit 3 or on a borrow into bit 3.
- R6: Parity is set when the low 8 result bits hold an even number of ones, in both widths. Opcodes 0 to 6 refresh it.
- R7: Opcodes 0 to 6 set zero when the result in the selected width is zero. They copy the top bit of that width into sign.
- R8: After opcodes 0 to 3, overflow is set when the signed result does not fit in the selected width.
- R9: Opcodes 4, 5 and 6 give A AND B, A OR B and A XOR B. They clear carry, overflow and auxiliary carry.
- R10: Opcode 7 passes B to the result and leaves every flag unchanged.
- R11: Opcodes 8 and 9 clear and set trap, 10 and 11 do the same for interrupt enable, and 12 and 13 for direction. Opcodes 8 to 15 leave the result and the condition flags unchanged. No other opcode changes a control flag.
- R12: With byte mode high, the operation acts on the low bytes and result bits 15 to 8 are zero.
- R13: With the strobe low, the result and the flag word keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Update strobe |
| opcode | input | 4 | Operation or control command |
| byte_mode | input | 1 | 1 = low-byte operation, 0 = word |
| src_a | input | 16 | Operand A |
| src_b | input | 16 | Operand B |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word |

## Verification
The checker assumes that opcode, byte_mode and both operands are known and stable at each rising edge where op_valid is high. It also assumes that reset is applied at start-up before the flag word is read. Every 4-bit opcode value is defined, so the checker needs no assumption on its range. The bench changes inputs only on falling edges and draws every opcode, both widths and strobe-low cycles from a seeded generator. It adds directed edge cases for carry chaining, signed overflow and control-flag commands.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADC    = 4'd1,
    OP_SUB    = 4'd2,
    OP_SBB    = 4'd3,
    OP_AND    = 4'd4,
    OP_OR     = 4'd5,
    OP_XOR    = 4'd6,
    OP_PASS   = 4'd7,
    OP_TF_CLR = 4'd8,
    OP_TF_SET = 4'd9,
    OP_IF_CLR = 4'd10,
    OP_IF_SET = 4'd11,
    OP_DF_CLR = 4'd12,
    OP_DF_SET = 4'd13,
    OP_NOP_E  = 4'd14,
    OP_NOP_F  = 4'd15
  } alu_op_e;

  localparam int FLAG_W = 16;
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;
  localparam logic [FLAG_W-1:0] FLAG_USED = 16'h0FD5;

  // even count of ones in a byte
  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction

  // signed overflow from operand and result sign bits
  function automatic logic signed_ovf(input logic a_s, input logic b_s,
                                      input logic r_s, input logic is_sub);
    if (is_sub) return (a_s != b_s) && (r_s != a_s);
    else        return (a_s == b_s) && (r_s != a_s);
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  input  logic              byte_mode,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              aux,
  output logic              ovf
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] wa, wb;
  logic [DATA_W:0]   raw;
  logic              use_cin, is_sub;
  logic              a_s, b_s, r_s;

  assign wa      = byte_mode ? {{HI_W{1'b0}}, a[LO_W-1:0]} : a;
  assign wb      = byte_mode ? {{HI_W{1'b0}}, b[LO_W-1:0]} : b;
  assign use_cin = (op == OP_ADC) || (op == OP_SBB);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBB);

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC: raw = {1'b0, wa} + {1'b0, wb} + {{DATA_W{1'b0}}, use_cin & cin};
      OP_SUB, OP_SBB: raw = {1'b0, wa} - {1'b0, wb} - {{DATA_W{1'b0}}, use_cin & cin};
      OP_AND:         raw = {1'b0, wa & wb};
      OP_OR:          raw = {1'b0, wa | wb};
      OP_XOR:         raw = {1'b0, wa ^ wb};
      default:        raw = {1'b0, wb};
    endcase
  end

  assign res   = byte_mode ? {{HI_W{1'b0}}, raw[LO_W-1:0]} : raw[DATA_W-1:0];
  assign carry = byte_mode ? raw[LO_W] : raw[DATA_W];
  assign aux   = wa[4] ^ wb[4] ^ raw[4];
  assign a_s   = byte_mode ? wa[LO_W-1] : wa[DATA_W-1];
  assign b_s   = byte_mode ? wb[LO_W-1] : wb[DATA_W-1];
  assign r_s   = byte_mode ? raw[LO_W-1] : raw[DATA_W-1];
  assign ovf   = signed_ovf(a_s, b_s, r_s, is_sub);
endmodule

// File: rtl/alu16_cond.sv
module alu16_cond
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  input  logic              byte_mode,
  output logic              zero,
  output logic              sign,
  output logic              parity
);
  localparam int LO_W = DATA_W / 2;

  assign zero   = byte_mode ? (res[LO_W-1:0] == '0) : (res == '0);
  assign sign   = byte_mode ? res[LO_W-1] : res[DATA_W-1];
  assign parity = even_ones8(res[7:0]);
endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
  import alu16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [3:0]        op,
  input  logic              carry,
  input  logic              aux,
  input  logic              ovf,
  input  logic              zero,
  input  logic              sign,
  input  logic              parity,
  output logic [FLAG_W-1:0] flag_q
);
  logic              arith_op, logic_op, ctl_op;
  logic              cond_load, ctl_load;
  logic [FLAG_W-1:0] flag_d;

  assign arith_op  = (op <= OP_SBB);
  assign logic_op  = (op >= OP_AND) && (op <= OP_XOR);
  assign ctl_op    = (op >= OP_TF_CLR) && (op <= OP_DF_SET);
  assign cond_load = upd && (arith_op || logic_op);
  assign ctl_load  = upd && ctl_op;

  always_comb begin
    flag_d = flag_q;
    if (cond_load) begin
      flag_d[CF_POS] = arith_op & carry;
      flag_d[AF_POS] = arith_op & aux;
      flag_d[OF_POS] = arith_op & ovf;
      flag_d[ZF_POS] = zero;
      flag_d[SF_POS] = sign;
      flag_d[PF_POS] = parity;
    end
    if (ctl_load) begin
      unique case (op)
        OP_TF_CLR, OP_TF_SET: flag_d[TF_POS] = op[0];
        OP_IF_CLR, OP_IF_SET: flag_d[IF_POS] = op[0];
        default:              flag_d[DF_POS] = op[0];
      endcase
    end
    flag_d = flag_d & FLAG_USED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        opcode,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  logic [DATA_W-1:0] alu_res;
  logic              alu_carry, alu_aux, alu_ovf;
  logic              res_zero, res_sign, res_parity;
  logic              dp_load;
  logic [DATA_W-1:0] result_q;

  alu16_arith #(.DATA_W(DATA_W)) u_arith (
    .a(src_a), .b(src_b), .op(opcode), .byte_mode(byte_mode),
    .cin(flags[CF_POS]), .res(alu_res), .carry(alu_carry),
    .aux(alu_aux), .ovf(alu_ovf)
  );

  alu16_cond #(.DATA_W(DATA_W)) u_cond (
    .res(alu_res), .byte_mode(byte_mode),
    .zero(res_zero), .sign(res_sign), .parity(res_parity)
  );

  alu16_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(op_valid), .op(opcode),
    .carry(alu_carry), .aux(alu_aux), .ovf(alu_ovf),
    .zero(res_zero), .sign(res_sign), .parity(res_parity),
    .flag_q(flags)
  );

  assign dp_load = op_valid && (opcode <= OP_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_q <= '0;
    else if (dp_load) result_q <= alu_res;
  end

  assign result = result_q;
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk
  import alu16_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  opcode,
  input logic        byte_mode,
  input logic [15:0] result,
  input logic [15:0] flags
);
  // R1
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAG_USED) == 16'h0);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags) && $stable(result));

  // R11
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode <= 4'd7 |=> flags[10:8] == $past(flags[10:8]));

  // R11
  df_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == 4'd13 |=> flags[DF_POS]);

  // R9
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode >= 4'd4 && opcode <= 4'd6 |=>
      !flags[CF_POS] && !flags[OF_POS] && !flags[AF_POS]);

  // R12
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && byte_mode && opcode <= 4'd7 |=> result[15:8] == 8'h00);

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode <= 4'd6 |=>
      flags[ZF_POS] == ($past(byte_mode) ? (result[7:0] == 8'h00) : (result == 16'h0)));

  // R10
  pass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == 4'd7 |=> $stable(flags));
endmodule

bind alu16_flags alu16_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .byte_mode(byte_mode), .result(result), .flags(flags)
);

// File: tb/alu16_flags_test.sv
module alu16_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic        byte_mode = 1'b0;
  logic [15:0] src_a = 16'h0;
  logic [15:0] src_b = 16'h0;
  logic [15:0] result;
  logic [15:0] flags;

  int checks = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] exp_r = 16'h0;
  logic [15:0] exp_f = 16'h0;

  always #4 clk = ~clk;

  alu16_flags uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .byte_mode(byte_mode), .src_a(src_a), .src_b(src_b),
    .result(result), .flags(flags)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model, integer arithmetic
  task automatic model(input bit v, input logic [3:0] op, input bit bm,
                       input logic [15:0] a, input logic [15:0] b);
    int mask, ua, ub, t, cin, sa, sb, st, hi, lo;
    bit add;
    logic [15:0] r;
    if (!v) return;
    mask = bm ? 255 : 65535;
    hi   = bm ? 127 : 32767;
    lo   = bm ? -128 : -32768;
    ua = int'(a) & mask;
    ub = int'(b) & mask;
    sa = bm ? int'($signed(a[7:0])) : int'($signed(a));
    sb = bm ? int'($signed(b[7:0])) : int'($signed(b));
    if (op <= 4'd3) begin
      add = (op <= 4'd1);
      cin = (op == 4'd1 || op == 4'd3) ? int'(exp_f[0]) : 0;
      if (add) begin
        t = ua + ub + cin;
        exp_f[0] = (t > mask);
        exp_f[4] = (((ua & 15) + (ub & 15) + cin) > 15);
        st = sa + sb + cin;
      end else begin
        t = ua - ub - cin;
        exp_f[0] = (t < 0);
        exp_f[4] = (((ua & 15) - (ub & 15) - cin) < 0);
        st = sa - sb - cin;
      end
      exp_f[11] = (st > hi) || (st < lo);
      r = 16'(t & mask);
    end else if (op <= 4'd6) begin
      if (op == 4'd4)      r = 16'(ua & ub);
      else if (op == 4'd5) r = 16'(ua | ub);
      else                 r = 16'(ua ^ ub);
      exp_f[0] = 0; exp_f[4] = 0; exp_f[11] = 0;
    end else begin
      r = 16'(ub);
    end
    if (op <= 4'd6) begin
      exp_f[6] = (r == 16'h0);
      exp_f[7] = bm ? r[7] : r[15];
      exp_f[2] = ($countones(r[7:0]) % 2) == 0;
    end
    if (op <= 4'd7) exp_r = r;
    if (op >= 4'd8 && op <= 4'd13) exp_f[8 + (int'(op) - 8) / 2] = op[0];
  endtask

  task automatic step(input bit v, input logic [3:0] op, input bit bm,
                      input logic [15:0] a, input logic [15:0] b);
    string tc;
    op_valid = v; opcode = op; byte_mode = bm; src_a = a; src_b = b;
    model(v, op, bm, a, b);
    @(posedge clk);
    @(negedge clk);
    if (!v) begin
      check("R13", "result idle", result, exp_r);
      check("R13", "flags idle", flags, exp_f);
      return;
    end
    tc = (op < 2) ? "R3" : (op < 4) ? "R4" : (op < 7) ? "R9" : (op == 7) ? "R10" : "R11";
    check(tc, "result", result, exp_r);
    check("R1", "unused bits", flags & 16'hF02A, 16'h0);
    check(tc, "CF", {15'h0, flags[0]}, {15'h0, exp_f[0]});
    check(op < 4 ? "R5" : tc, "AF", {15'h0, flags[4]}, {15'h0, exp_f[4]});
    check(op < 7 ? "R6" : tc, "PF", {15'h0, flags[2]}, {15'h0, exp_f[2]});
    check(op < 7 ? "R7" : tc, "ZF/SF", {14'h0, flags[7:6]}, {14'h0, exp_f[7:6]});
    check(op < 4 ? "R8" : tc, "OF", {15'h0, flags[11]}, {15'h0, exp_f[11]});
    check("R11", "control", {13'h0, flags[10:8]}, {13'h0, exp_f[10:8]});
    if (bm && op <= 4'd7) check("R12", "upper byte", {8'h0, result[15:8]}, 16'h0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R2", "result in reset", result, 16'h0);
    check("R2", "flags in reset", flags, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "result after reset", result, 16'h0);
    check("R2", "flags after reset", flags, 16'h0);

    step(1, 4'd0, 0, 16'hFFFF, 16'h0001); // R3 carry, zero, aux, parity
    step(1, 4'd1, 0, 16'h0001, 16'h0001); // R3 carry in -> 3
    step(1, 4'd0, 0, 16'h7FFF, 16'h0001); // R8 overflow
    step(1, 4'd2, 0, 16'h0000, 16'h0001); // R4 borrow
    step(1, 4'd3, 0, 16'h0005, 16'h0002); // R4 borrow in -> 2
    step(1, 4'd2, 1, 16'h1280, 16'h3401); // R12 R8 byte overflow
    step(1, 4'd0, 1, 16'hAAFF, 16'h5501); // R12 byte carry
    step(1, 4'd0, 0, 16'h0008, 16'h0008); // R5 aux carry
    step(1, 4'd2, 0, 16'h0010, 16'h0001); // R5 aux borrow
    step(1, 4'd13, 0, 16'h1234, 16'h5678); // R11 DF set
    step(1, 4'd11, 0, 16'h0, 16'h0);       // R11 IF set
    step(1, 4'd9, 0, 16'h0, 16'h0);        // R11 TF set
    step(1, 4'd0, 0, 16'h1111, 16'h2222);  // R11 arithmetic keeps control
    step(1, 4'd4, 0, 16'hF0F0, 16'h0FF0);  // R9 and
    step(1, 4'd6, 0, 16'hFFFF, 16'hFFFF);  // R9 xor -> zero
    step(1, 4'd7, 1, 16'h0, 16'hBEEF);     // R10 pass byte
    step(1, 4'd12, 0, 16'h0, 16'h0);       // R11 DF clear
    step(0, 4'd0, 0, 16'h1234, 16'h4321);  // R13 idle
    step(1, 4'd0, 0, 16'h0100, 16'h0000);  // R6 parity low byte only

    for (int i = 0; i < 600; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[3:0] != 4'd0, 4'($urandom), rv[4], 16'($urandom), 16'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule